// File: doc/BRIEF.md
# Indirect Shadow Register Access Unit

This block is the management-side register file of a transceiver. A simple register port drives it: a 5-bit register address, 16-bit write data, a single-cycle write strobe and a single-cycle read strobe. This is the kind of port an MDIO slave presents after it has decoded a frame. The block holds two kinds of hidden storage behind a small number of visible addresses.

The first kind is a set of 32 shadow registers, each 10 bits wide. All of them sit behind one multiplexed address, 0x1C. Bit 15 of the word written there sets the kind of access. When bit 15 is set, the low 10 bits are stored into the entry named by bits 14:10. When bit 15 is clear, bits 14:10 are only latched as the selector that a later read uses.

The second kind is an expansion space reached through a select/data pair. Software writes a 16-bit expansion address to the select register at 0x17. It then reads or writes the data register at 0x15. Bits 11:8 of the expansion address carry a bank code, and the low bits give the offset within the bank. Software returns the select register to 0 after each access, and in that state the data register reaches no storage.

Top module: `ind_shadow_regs`

## Requirements
- R1: On synchronous active-high reset, all shadow entries, the shadow selector, the expansion select and every expansion entry become 0, rdata becomes 0x0000 and rd_valid becomes 0.
- R2: rd_valid is high exactly in the cycle after a cycle with rd_en high, and rdata changes only in that cycle. rdata holds its value in all other cycles.
- R3: A write to address 0x1C with bit 15 set stores bits 9:0 into the shadow entry whose index is bits 14:10. The shadow selector is left unchanged.
- R4: A write to address 0x1C with bit 15 clear loads bits 14:10 into the shadow selector. No shadow entry changes, whatever bits 9:0 hold.
- R5: A read of address 0x1C returns 0 in bit 15, the current selector in bits 14:10 and the selected entry's data in bits 9:0.
- R6: Address 0x17 is a 16-bit expansion select register that reads back exactly the value last written to it.
- R7: The expansion select maps to storage when bits 15:12 and 7:4 are 0 and bits 11:8 hold a known bank code. Code 0xF names the general bank and code 0xE names the secondary bank. Bits 3:0 pick one of 16 entries in that bank. Address 0x15 then reads and writes that 16-bit entry.
- R8: When the select does not map to storage, writes to 0x15 change no expansion entry and reads of 0x15 return 0x0000. This includes a select of 0, an unknown bank code, and nonzero bits in 15:12 or 7:4.
- R9: Reads of any address other than 0x1C, 0x17 and 0x15 return 0x0000. Writes to such addresses change no state.
- R10: When a read and a write occur in the same cycle, the read returns the state from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 5 | Register address for both strobes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| rd_valid | output | 1 | rdata holds the answer to the previous cycle's read |

## Verification
A read and a write can arrive in the same cycle at the same visible address. The cases are a selector change at 0x1C while 0x1C is read, and a data write at 0x15 while 0x15 is read. The bench raises both strobes together in those two cases. It expects the returned word to match its model's state from before the write. A plain read in the next cycle must then show the new state.

// File: rtl/ind_shadow_pkg.sv
package ind_shadow_pkg;
    localparam int REG_AW = 5;
    localparam int REG_DW = 16;

    typedef logic [REG_AW-1:0] reg_addr_t;
    typedef logic [REG_DW-1:0] reg_word_t;

    // visible register addresses
    localparam reg_addr_t ADDR_SHADOW = 5'h1C;
    localparam reg_addr_t ADDR_XSEL   = 5'h17;
    localparam reg_addr_t ADDR_XDATA  = 5'h15;

    // fields of the multiplexed shadow word
    localparam int SHD_STORE_BIT = 15;
    localparam int SHD_IDX_LSB   = 10;
    localparam int SHD_DW        = 10;

    // expansion address layout
    localparam int XBANK_LSB = 8;
    localparam int XBANK_W   = 4;
endpackage

// File: rtl/ind_shadow_file.sv
module ind_shadow_file #(
    parameter int NUM = 32,
    parameter int DW  = 10,
    localparam int IW = $clog2(NUM)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          store_en,
    input  logic          sel_en,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] din,
    output logic [IW-1:0] sel_q,
    output logic [DW-1:0] sel_data
);
    typedef struct packed {
        logic [IW-1:0]          sel;
        logic [NUM-1:0][DW-1:0] mem;
    } shd_state_t;

    shd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_en) begin
            st_d.sel = idx;
        end
        if (store_en) begin
            st_d.mem[idx] = din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_q    = st_q.sel;
    assign sel_data = st_q.mem[st_q.sel];
endmodule

// File: rtl/ind_exp_bank.sv
module ind_exp_bank #(
    parameter int DEPTH = 16,
    parameter int DW    = 16,
    localparam int OW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [OW-1:0] off,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.mem[off] = din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.mem[off];
endmodule

// File: rtl/ind_exp_space.sv
module ind_exp_space
    import ind_shadow_pkg::*;
#(
    parameter int                  NBANKS     = 2,
    parameter int                  DEPTH      = 16,
    parameter logic [NBANKS*4-1:0] BANK_CODES = 8'hEF,
    localparam int                 OW         = $clog2(DEPTH)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sel_we,
    input  logic      data_we,
    input  reg_word_t din,
    output reg_word_t sel_q,
    output reg_word_t data_out,
    output logic      hit
);
    // bits that may be nonzero in a mapped expansion address
    localparam reg_word_t MAP_MASK =
        reg_word_t'(((1 << XBANK_W) - 1) << XBANK_LSB) | reg_word_t'(DEPTH - 1);

    typedef struct packed {
        reg_word_t sel;
    } xsel_state_t;

    xsel_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_we) begin
            st_d.sel = din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic               spare_clear;
    logic [XBANK_W-1:0] code;
    logic [OW-1:0]      off;
    logic [NBANKS-1:0]  bank_hit;
    reg_word_t          bank_dout [NBANKS];

    assign spare_clear = (st_q.sel & ~MAP_MASK) == '0;
    assign code        = st_q.sel[XBANK_LSB +: XBANK_W];
    assign off         = st_q.sel[OW-1:0];

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        assign bank_hit[b] = spare_clear && (code == BANK_CODES[b*4 +: 4]);

        ind_exp_bank #(
            .DEPTH (DEPTH),
            .DW    (REG_DW)
        ) u_bank (
            .clk  (clk),
            .rst  (rst),
            .we   (data_we && bank_hit[b]),
            .off  (off),
            .din  (din),
            .dout (bank_dout[b])
        );
    end

    always_comb begin
        data_out = '0;
        for (int b = 0; b < NBANKS; b++) begin
            if (bank_hit[b]) begin
                data_out = data_out | bank_dout[b];
            end
        end
    end

    assign hit   = |bank_hit;
    assign sel_q = st_q.sel;
endmodule

// File: rtl/ind_shadow_regs.sv
module ind_shadow_regs
    import ind_shadow_pkg::*;
#(
    parameter int                    NUM_SHADOW  = 32,
    parameter int                    XBANK_DEPTH = 16,
    parameter int                    NXBANKS     = 2,
    parameter logic [NXBANKS*4-1:0]  XBANK_CODES = 8'hEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [4:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        rd_valid
);
    localparam int SHD_IW = $clog2(NUM_SHADOW);

    // ---------------- write decode ----------------
    logic shd_access, shd_store, shd_select;
    logic xsel_we, xdata_we;

    assign shd_access = wr_en && (addr == ADDR_SHADOW);
    assign shd_store  = shd_access && wdata[SHD_STORE_BIT];
    assign shd_select = shd_access && !wdata[SHD_STORE_BIT];
    assign xsel_we    = wr_en && (addr == ADDR_XSEL);
    assign xdata_we   = wr_en && (addr == ADDR_XDATA);

    // ---------------- storage ----------------
    logic [SHD_IW-1:0] shd_sel;
    logic [SHD_DW-1:0] shd_data;
    reg_word_t         xsel_q, xdata;
    logic              xhit;

    ind_shadow_file #(
        .NUM (NUM_SHADOW),
        .DW  (SHD_DW)
    ) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .store_en (shd_store),
        .sel_en   (shd_select),
        .idx      (wdata[SHD_IDX_LSB +: SHD_IW]),
        .din      (wdata[SHD_DW-1:0]),
        .sel_q    (shd_sel),
        .sel_data (shd_data)
    );

    ind_exp_space #(
        .NBANKS     (NXBANKS),
        .DEPTH      (XBANK_DEPTH),
        .BANK_CODES (XBANK_CODES)
    ) u_exp (
        .clk      (clk),
        .rst      (rst),
        .sel_we   (xsel_we),
        .data_we  (xdata_we),
        .din      (wdata),
        .sel_q    (xsel_q),
        .data_out (xdata),
        .hit      (xhit)
    );

    // ---------------- read path ----------------
    typedef struct packed {
        reg_word_t rdata;
        logic      valid;
    } rd_state_t;

    rd_state_t rd_d, rd_q;
    reg_word_t rd_word;

    always_comb begin
        unique case (addr)
            ADDR_SHADOW: rd_word = reg_word_t'({1'b0, shd_sel, shd_data});
            ADDR_XSEL:   rd_word = xsel_q;
            ADDR_XDATA:  rd_word = xhit ? xdata : '0;
            default:     rd_word = '0;
        endcase
    end

    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = rd_en;
        if (rd_en) begin
            rd_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata    = rd_q.rdata;
    assign rd_valid = rd_q.valid;
endmodule

// File: rtl/ind_shadow_regs_chk.sv
module ind_shadow_regs_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        rd_en,
    input logic [4:0]  addr,
    input logic [15:0] wdata,
    input logic [15:0] rdata,
    input logic        rd_valid,
    input logic [4:0]  shd_sel,
    input logic        xhit
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (rdata == 16'h0 && !rd_valid));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    a_r2_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    a_r2_data_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    a_r3_select_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 5'h1C && wdata[15]) |=> $stable(shd_sel));

    a_r4_select_loaded: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 5'h1C && !wdata[15]) |=> (shd_sel == $past(wdata[14:10])));

    a_r5_flag_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 5'h1C) |=> !rdata[15]);

    a_r5_selector_field: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 5'h1C) |=> (rdata[14:10] == $past(shd_sel)));

    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 5'h15 && !xhit) |=> (rdata == 16'h0));

    a_r9_other_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr != 5'h1C && addr != 5'h17 && addr != 5'h15) |=> (rdata == 16'h0));
endmodule

bind ind_shadow_regs ind_shadow_regs_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .rd_valid (rd_valid),
    .shd_sel  (shd_sel),
    .xhit     (xhit)
);

// File: tb/sim_ind_shadow_regs.sv
module sim_ind_shadow_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rd_valid;

    always #5 clk = ~clk;

    ind_shadow_regs u0 (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .rd_valid (rd_valid)
    );

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    // scoreboard
    logic [15:0] exp_q [$];
    string       tag_q [$];
    logic [15:0] last_seen = 16'h0;

    // requirement-level model
    logic [9:0]  m_shd [32];
    logic [4:0]  m_sel;
    logic [15:0] m_xsel;
    logic [15:0] m_xb [2][16];

    function automatic bit x_mapped(input logic [15:0] s, output int bank);
        bank = 0;
        if ((s & 16'hF0F0) != 16'h0) return 0;
        if (s[11:8] == 4'hF) begin bank = 0; return 1; end
        if (s[11:8] == 4'hE) begin bank = 1; return 1; end
        return 0;
    endfunction

    function automatic logic [15:0] model_read(input logic [4:0] a);
        int b;
        case (a)
            5'h1C: return {1'b0, m_sel, m_shd[m_sel]};
            5'h17: return m_xsel;
            5'h15: return x_mapped(m_xsel, b) ? m_xb[b][m_xsel[3:0]] : 16'h0;
            default: return 16'h0;
        endcase
    endfunction

    task automatic model_write(input logic [4:0] a, input logic [15:0] d);
        int b;
        if (a == 5'h1C) begin
            if (d[15]) m_shd[d[14:10]] = d[9:0];
            else       m_sel = d[14:10];
        end else if (a == 5'h17) begin
            m_xsel = d;
        end else if (a == 5'h15) begin
            if (x_mapped(m_xsel, b)) m_xb[b][m_xsel[3:0]] = d;
        end
    endtask

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        model_write(a, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(model_read(a));
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // read and write raised in the same cycle (R10)
    task automatic both(input logic [4:0] wa, input logic [15:0] wd,
                        input logic [4:0] ra, input string tag);
        @(negedge clk);
        exp_q.push_back(model_read(ra));
        tag_q.push_back(tag);
        model_write(wa, wd);
        wr_en = 1'b1; rd_en = 1'b1;
        addr = wa; wdata = wd;
        if (wa != ra) $display("bench note: addresses differ");
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic xrd(input logic [15:0] sel, input string tag);
        wr(5'h17, sel);
        rd(5'h15, tag);
        wr(5'h17, 16'h0);
    endtask

    task automatic xwr(input logic [15:0] sel, input logic [15:0] d);
        wr(5'h17, sel);
        wr(5'h15, d);
        wr(5'h17, 16'h0);
    endtask

    // monitor: pops expected answers as results appear
    always @(negedge clk) begin
        if (!rst && !ended) begin
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R2: unexpected rd_valid, actual %h expected no read", rdata);
                end else begin
                    check(rdata, exp_q.pop_front(), tag_q.pop_front());
                    last_seen = rdata;
                end
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        foreach (m_shd[i]) m_shd[i] = '0;
        foreach (m_xb[b, i]) m_xb[b][i] = '0;
        m_sel = '0; m_xsel = '0;

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check(rdata, 16'h0, "R1 rdata after reset");
        check({15'h0, rd_valid}, 16'h0, "R1 rd_valid after reset");
        rd(5'h1C, "R1 shadow reset");
        rd(5'h17, "R1 select reset");
        xrd(16'h0F05, "R1 general bank reset");
        xrd(16'h0E0A, "R1 secondary bank reset");

        // R3 / R5 basic shadow store and select
        wr(5'h1C, 16'h8000 | (16'd5 << 10) | 16'h2AB);
        wr(5'h1C, 16'd5 << 10);
        rd(5'h1C, "R5 shadow entry 5");
        wr(5'h1C, 16'h8000 | (16'd9 << 10) | 16'h155);
        rd(5'h1C, "R3 store keeps selector");
        wr(5'h1C, 16'd9 << 10);
        rd(5'h1C, "R3 entry 9 stored");

        // all entries
        for (int i = 0; i < 32; i++)
            wr(5'h1C, 16'h8000 | 16'(i << 10) | 16'((i * 37 + 3) & 16'h3FF));
        for (int i = 0; i < 32; i++) begin
            wr(5'h1C, 16'(i << 10));
            rd(5'h1C, "R5 entry sweep");
        end

        // R4 selector write with nonzero low bits changes no entry
        wr(5'h1C, (16'd7 << 10) | 16'h3FF);
        rd(5'h1C, "R4 entry 7 untouched");
        wr(5'h1C, (16'd31 << 10) | 16'h155);
        rd(5'h1C, "R4 entry 31 untouched");

        // R6 select readback
        wr(5'h17, 16'hABCD);
        rd(5'h17, "R6 select readback");
        wr(5'h17, 16'h0);

        // R7 both banks
        xwr(16'h0F03, 16'h1234);
        xwr(16'h0E03, 16'h5678);
        xrd(16'h0F03, "R7 general bank offset 3");
        xrd(16'h0E03, "R7 secondary bank offset 3");
        for (int i = 0; i < 16; i++) begin
            xwr(16'h0F00 | 16'(i), 16'hA000 + 16'(i * 17));
            xwr(16'h0E00 | 16'(i), 16'h5000 + 16'(i * 29));
        end
        for (int i = 0; i < 16; i++) begin
            xrd(16'h0F00 | 16'(i), "R7 general sweep");
            xrd(16'h0E00 | 16'(i), "R7 secondary sweep");
        end

        // R8 unmapped selects
        wr(5'h17, 16'h0);
        wr(5'h15, 16'hFFFF);
        rd(5'h15, "R8 select zero reads zero");
        xwr(16'h0D03, 16'hDEAD);
        xrd(16'h0D03, "R8 unknown bank");
        xwr(16'h0F13, 16'hBEEF);
        xrd(16'h0F13, "R8 spare bit set");
        xwr(16'h1E03, 16'hCAFE);
        xrd(16'h1E03, "R8 high bits set");
        xrd(16'h0F03, "R8 general entry untouched");
        xrd(16'h0E03, "R8 secondary entry untouched");
        xrd(16'h0F00, "R8 general entry 0 untouched");

        // R9 other addresses
        wr(5'h00, 16'hFFFF);
        wr(5'h1D, 16'h8000 | (16'd2 << 10) | 16'h3FF);
        rd(5'h00, "R9 other address zero");
        rd(5'h1F, "R9 other address zero");
        rd(5'h1C, "R9 shadow state untouched");
        rd(5'h17, "R9 select untouched");

        // R10 same-cycle read and write
        both(5'h1C, 16'd3 << 10, 5'h1C, "R10 selector write same cycle");
        rd(5'h1C, "R10 new selector visible");
        wr(5'h17, 16'h0E07);
        both(5'h15, 16'h7777, 5'h15, "R10 data write same cycle");
        rd(5'h15, "R10 new data visible");
        wr(5'h17, 16'h0);

        // R2 hold while idle
        rd(5'h17, "R2 read before idle");
        repeat (5) @(negedge clk);
        check(rdata, last_seen, "R2 rdata held while idle");
        check({15'h0, rd_valid}, 16'h0, "R2 rd_valid low while idle");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R2: actual %0d reads pending expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule